// File: doc/BRIEF.md
# Inbound Bus-Master Address Window Bank

This block holds a small set of inbound address windows that translate addresses issued by bus masters on the I/O side into local addresses. Every window covers a power-of-two-style span that starts at bus address zero. It is described by a 64-bit size word and a 64-bit local base. The size word also carries the enable in its bit 0. Software programs the windows through a 32-bit register port with word addresses. The port also carries a plain 32-bit status storage register.

For each bus-master address presented on `bm_addr`, the block reports in the same cycle whether a window matched, which window matched, and the translated local address. If windows overlap, the lowest-numbered window is used. If no window matches, the address is returned unchanged and the hit flag stays low. Window 1 is built as a narrow variant: its size is programmed through a single 32-bit register, and the parameter `NARROW_MASK` selects which windows take this form.

Top module: `inb_win_bank`

## Requirements
- R1: After reset every size word is 0xFFFFFFFF_00000000, every local base is zero and the status register is zero, so no window matches any address.
- R2: Register byte address = 16*window + 4*field, with field 0 size low, 1 size high, 2 base low and 3 base high. A write to one 32-bit half of a base or of a split size word leaves the other half unchanged, and every field reads back what was written.
- R3: On a narrow window (window 1 by default), a write to size low loads the whole 64-bit size word with the upper half cleared. Size high on that window reads zero, and writes to it have no effect.
- R4: A window with size-word bit 0 clear never matches.
- R5: The span of a window is the 65-bit two's complement of its size word with bits 2:0 forced to zero. An address matches when it lies in 0 to span-1, so bits 2:1 do not affect matching, and a masked size word of zero covers the whole 64-bit space.
- R6: On a match, `lk_addr` = local base + `bm_addr` modulo 2^64, and it is valid in the same cycle as `bm_addr`.
- R7: When several enabled windows match, `lk_hit` is 1 and `lk_win` gives the lowest matching index.
- R8: With no match, `lk_hit` is 0, `lk_win` is 0 and `lk_addr` equals `bm_addr`.
- R9: Byte address 0x30 is a 32-bit read/write status register. It changes only when it is written.
- R10: Byte addresses that are not word-aligned, and words 13 to 15, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | RAW (6) | Register byte address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Combinational read data for `reg_addr` |
| bm_addr | input | AW (64) | Bus-master address to translate |
| lk_hit | output | 1 | A window matched |
| lk_win | output | IW (2) | Index of the matching window, 0 on a miss |
| lk_addr | output | AW (64) | Translated or passed-through address |

## Verification
Two functions meet in one cycle: priority selection among overlapping windows and the pass-through fallback. Window 0 and window 2 are programmed to overlap, and later the narrow window 1 and a full-space window are added. Sweeps are then run over addresses just below, at and just above each span edge, and over pseudo-random addresses in small and very large ranges. Each result is compared with a bench model that computes spans in 65-bit arithmetic and picks the lowest matching index. An address that misses every window must come back unchanged, and one covered by two windows must take the lower window's base.

// File: rtl/inb_win_pkg.sv
package inb_win_pkg;
   // Field selector inside one window's four-word register group.
   typedef enum logic [1:0] {
      FLD_SIZE_LO = 2'd0,
      FLD_SIZE_HI = 2'd1,
      FLD_BASE_LO = 2'd2,
      FLD_BASE_HI = 2'd3
   } win_fld_e;
endpackage

// File: rtl/inb_win_regs.sv
module inb_win_regs
   import inb_win_pkg::*;
#(
   parameter int AW     = 64,
   parameter int DW     = 32,
   parameter bit NARROW = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  win_fld_e      fld,
   input  logic [DW-1:0] wdata,
   output logic [AW-1:0] size_q,
   output logic [AW-1:0] base_q,
   output logic [DW-1:0] rdata
);
   localparam logic [AW-1:0] SIZE_RST = {{(AW-DW){1'b1}}, {DW{1'b0}}};

   // Local base: two independently written halves.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (wr_en) begin
         if (fld == FLD_BASE_LO) base_q[DW-1:0]  <= wdata;
         if (fld == FLD_BASE_HI) base_q[AW-1:DW] <= wdata;
      end
   end

   // Size word: narrow variant loads the whole word from one register.
   if (NARROW) begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q <= SIZE_RST;
         end else if (wr_en && fld == FLD_SIZE_LO) begin
            size_q <= AW'(wdata);
         end
      end
   end else begin : g_split
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            size_q <= SIZE_RST;
         end else if (wr_en) begin
            if (fld == FLD_SIZE_LO) size_q[DW-1:0]  <= wdata;
            if (fld == FLD_SIZE_HI) size_q[AW-1:DW] <= wdata;
         end
      end
   end

   always_comb begin
      case (fld)
         FLD_SIZE_LO: rdata = size_q[DW-1:0];
         FLD_SIZE_HI: rdata = NARROW ? '0 : size_q[AW-1:DW];
         FLD_BASE_LO: rdata = base_q[DW-1:0];
         FLD_BASE_HI: rdata = base_q[AW-1:DW];
         default:     rdata = '0;
      endcase
   end
endmodule

// File: rtl/inb_win_match.sv
module inb_win_match #(
   parameter int AW = 64
) (
   input  logic [AW-1:0] size_q,
   input  logic [AW-1:0] base_q,
   input  logic [AW-1:0] addr,
   output logic          hit,
   output logic [AW-1:0] xlat
);
   localparam logic [AW-1:0] ATTR_CLR = ~AW'(7);

   logic [AW-1:0] mask;
   logic [AW:0]   span;

   // Span is computed one bit wider so that a zero mask means 2^AW.
   assign mask = size_q & ATTR_CLR;
   assign span = {1'b0, ~mask} + (AW+1)'(1);
   assign hit  = size_q[0] && ({1'b0, addr} < span);
   assign xlat = base_q + addr;
endmodule

// File: rtl/inb_win_arb.sv
module inb_win_arb #(
   parameter int N  = 3,
   parameter int AW = 64,
   parameter int IW = 2
) (
   input  logic [N-1:0]         hit_v,
   input  logic [N-1:0][AW-1:0] xlat_v,
   input  logic [AW-1:0]        addr,
   output logic                 hit,
   output logic [IW-1:0]        idx,
   output logic [AW-1:0]        out_addr
);
   // Walk from the highest index down so the lowest match is taken last.
   always_comb begin
      hit      = 1'b0;
      idx      = '0;
      out_addr = addr;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_v[i]) begin
            hit      = 1'b1;
            idx      = IW'(i);
            out_addr = xlat_v[i];
         end
      end
   end
endmodule

// File: rtl/inb_win_bank.sv
module inb_win_bank
   import inb_win_pkg::*;
#(
   parameter int             AW          = 64,
   parameter int             DW          = 32,
   parameter int             NWIN        = 3,
   parameter logic [NWIN-1:0] NARROW_MASK = 3'b010,
   parameter int             RAW         = 6,
   localparam int            IW          = (NWIN > 1) ? $clog2(NWIN) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_wr,
   input  logic [RAW-1:0] reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   input  logic [AW-1:0]  bm_addr,
   output logic           lk_hit,
   output logic [IW-1:0]  lk_win,
   output logic [AW-1:0]  lk_addr
);
   localparam int WW        = RAW - 2;
   localparam int SW        = WW - 2;
   localparam int STAT_WORD = NWIN * 4;

   if (AW != 2 * DW) begin : g_bad_width
      $error("inb_win_bank: AW must be twice DW");
   end
   if (STAT_WORD >= (1 << WW)) begin : g_bad_raw
      $error("inb_win_bank: RAW too small for window count");
   end

   logic [WW-1:0]            word;
   logic [SW-1:0]            wsel;
   logic                     aligned;
   win_fld_e                 fld;
   logic [NWIN-1:0][AW-1:0]  size_q;
   logic [NWIN-1:0][AW-1:0]  base_q;
   logic [NWIN-1:0][AW-1:0]  xlat_v;
   logic [NWIN-1:0][DW-1:0]  rd_v;
   logic [NWIN-1:0]          win_hit;
   logic [DW-1:0]            stat_q;

   assign word    = reg_addr[RAW-1:2];
   assign wsel    = word[WW-1:2];
   assign aligned = (reg_addr[1:0] == 2'b00);
   assign fld     = win_fld_e'(word[1:0]);

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      logic wr_w;
      assign wr_w = reg_wr && aligned && (wsel == SW'(w));

      inb_win_regs #(
         .AW    (AW),
         .DW    (DW),
         .NARROW(NARROW_MASK[w])
      ) u_regs (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr_w),
         .fld   (fld),
         .wdata (reg_wdata),
         .size_q(size_q[w]),
         .base_q(base_q[w]),
         .rdata (rd_v[w])
      );

      inb_win_match #(
         .AW(AW)
      ) u_match (
         .size_q(size_q[w]),
         .base_q(base_q[w]),
         .addr  (bm_addr),
         .hit   (win_hit[w]),
         .xlat  (xlat_v[w])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else if (reg_wr && aligned && word == WW'(STAT_WORD)) begin
         stat_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (aligned) begin
         if (word == WW'(STAT_WORD)) reg_rdata = stat_q;
         for (int w = 0; w < NWIN; w++) begin
            if (wsel == SW'(w)) reg_rdata = rd_v[w];
         end
      end
   end

   inb_win_arb #(
      .N (NWIN),
      .AW(AW),
      .IW(IW)
   ) u_arb (
      .hit_v   (win_hit),
      .xlat_v  (xlat_v),
      .addr    (bm_addr),
      .hit     (lk_hit),
      .idx     (lk_win),
      .out_addr(lk_addr)
   );
endmodule

// File: rtl/inb_win_bank_chk.sv
module inb_win_bank_chk #(
   parameter int             AW          = 64,
   parameter int             DW          = 32,
   parameter int             NWIN        = 3,
   parameter logic [NWIN-1:0] NARROW_MASK = 3'b010,
   parameter int             RAW         = 6,
   parameter int             IW          = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_wr,
   input logic [RAW-1:0]          reg_addr,
   input logic [AW-1:0]           bm_addr,
   input logic                    lk_hit,
   input logic [IW-1:0]           lk_win,
   input logic [AW-1:0]           lk_addr,
   input logic [NWIN-1:0][AW-1:0] size_q,
   input logic [NWIN-1:0][AW-1:0] base_q,
   input logic [NWIN-1:0]         win_hit,
   input logic [DW-1:0]           stat_q
);
   localparam int STAT_BYTE = NWIN * 16;

   // R1: first cycle out of reset has no match and a cleared status
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!lk_hit && stat_q == '0));

   // R4: a reported match comes from an enabled window
   assert_hit_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> size_q[lk_win][0]);

   // R7: no lower-indexed window also matched
   assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> ((win_hit & ((NWIN'(1) << lk_win) - NWIN'(1))) == '0));

   // R8: a miss leaves the address untouched
   assert_miss_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_addr == bm_addr && lk_win == '0 && win_hit == '0));

   // R9: status changes only through its own word
   assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == RAW'(STAT_BYTE)) |=> $stable(stat_q));

   for (genvar w = 0; w < NWIN; w++) begin : g_w
      // R2: writing base low keeps base high
      assert_base_keep_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_addr == RAW'(w * 16 + 8)) |=> $stable(base_q[w][AW-1:DW]));
      if (NARROW_MASK[w]) begin : g_nar
         // R3: narrow size write clears the upper half
         assert_narrow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == RAW'(w * 16)) |=> (size_q[w][AW-1:DW] == '0));
      end
   end
endmodule

bind inb_win_bank inb_win_bank_chk #(
   .AW         (AW),
   .DW         (DW),
   .NWIN       (NWIN),
   .NARROW_MASK(NARROW_MASK),
   .RAW        (RAW),
   .IW         (IW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .reg_wr  (reg_wr),
   .reg_addr(reg_addr),
   .bm_addr (bm_addr),
   .lk_hit  (lk_hit),
   .lk_win  (lk_win),
   .lk_addr (lk_addr),
   .size_q  (size_q),
   .base_q  (base_q),
   .win_hit (win_hit),
   .stat_q  (stat_q)
);

// File: tb/inb_win_bank_tb.sv
`timescale 1ns/1ps
module inb_win_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [63:0] bm_addr = '0;
   logic        lk_hit;
   logic [1:0]  lk_win;
   logic [63:0] lk_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [63:0] m_size [3];
   logic [63:0] m_base [3];
   logic [31:0] m_stat;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #10 clk = ~clk;   // 50 MHz

   inb_win_bank u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bm_addr(bm_addr),
      .lk_hit(lk_hit), .lk_win(lk_win), .lk_addr(lk_addr)
   );

   function automatic logic [64:0] span_of(input logic [63:0] sz);
      return {1'b0, ~(sz & ~64'h7)} + 65'd1;
   endfunction

   task automatic model_lk(input logic [63:0] a, output logic h,
                           output logic [1:0] ix, output logic [63:0] la);
      h = 0; ix = 0; la = a;
      for (int w = 2; w >= 0; w--) begin
         if (m_size[w][0] && ({1'b0, a} < span_of(m_size[w]))) begin
            h = 1; ix = 2'(w); la = m_base[w] + a;
         end
      end
   endtask

   function automatic logic [31:0] model_rd(input logic [5:0] a);
      int wd, w, f;
      if (a[1:0] != 2'b00) return 32'h0;
      wd = int'(a[5:2]);
      if (wd == 12) return m_stat;
      if (wd > 12) return 32'h0;
      w = wd / 4; f = wd % 4;
      case (f)
         0: return m_size[w][31:0];
         1: return (w == 1) ? 32'h0 : m_size[w][63:32];
         2: return m_base[w][31:0];
         default: return m_base[w][63:32];
      endcase
   endfunction

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      int wd, w, f;
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      if (a[1:0] == 2'b00) begin
         wd = int'(a[5:2]);
         if (wd == 12) m_stat = d;
         else if (wd < 12) begin
            w = wd / 4; f = wd % 4;
            case (f)
               0: if (w == 1) m_size[w] = {32'h0, d}; else m_size[w][31:0] = d;
               1: if (w != 1) m_size[w][63:32] = d;
               2: m_base[w][31:0] = d;
               default: m_base[w][63:32] = d;
            endcase
         end
      end
   endtask

   task automatic rd_chk(input logic [5:0] a, input string req);
      logic [31:0] e;
      reg_addr = a;
      #2;
      e = model_rd(a);
      n_chk++;
      if (reg_rdata !== e) begin
         n_fail++;
         $display("FAIL %s read addr 0x%02h: actual 0x%08h expected 0x%08h", req, a, reg_rdata, e);
      end
   endtask

   task automatic lk_chk(input logic [63:0] a, input string req);
      logic h; logic [1:0] ix; logic [63:0] la;
      bm_addr = a;
      #2;
      model_lk(a, h, ix, la);
      n_chk++;
      if (lk_hit !== h || lk_win !== ix || lk_addr !== la) begin
         n_fail++;
         $display("FAIL %s lookup 0x%016h: actual hit=%0b win=%0d addr=0x%016h expected hit=%0b win=%0d addr=0x%016h",
                  req, a, lk_hit, lk_win, lk_addr, h, ix, la);
      end
   endtask

   task automatic edges(input int w, input string req);
      logic [64:0] s;
      s = span_of(m_size[w]);
      lk_chk(64'h0, req);
      lk_chk(s[63:0] - 64'd1, req);
      lk_chk(s[63:0], req);
      lk_chk(s[63:0] + 64'd1, req);
   endtask

   task automatic sweep(input int n, input string req);
      logic [63:0] a;
      for (int i = 0; i < n; i++) begin
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 7); rng = rng ^ (rng << 17);
         case (i % 4)
            0: a = rng & 64'h3FFF;
            1: a = rng & 64'h1_FFFF;
            2: a = rng;
            default: a = {32'hFFFF_FFFF, rng[31:0] & 32'h3FFF};
         endcase
         lk_chk(a, req);
      end
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < 3; w++) begin
         m_size[w] = 64'hFFFF_FFFF_0000_0000;
         m_base[w] = 64'h0;
      end
      m_stat = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 / R3 / R10: reset state over every word
      for (int a = 0; a < 64; a += 4) rd_chk(6'(a), "R1");
      rd_chk(6'h01, "R10");
      sweep(16, "R1");

      // R4: window 0 programmed but left disabled
      wr(6'h00, 32'hFFFF_F000);
      wr(6'h08, 32'h8000_0000);
      wr(6'h0C, 32'h0000_0001);
      lk_chk(64'h10, "R4");
      edges(0, "R4");

      // R5 / R6: enable window 0 with a 4 KiB span
      wr(6'h00, 32'hFFFF_F001);
      edges(0, "R5");
      lk_chk(64'h0000_0000_0000_0ABC, "R6");
      // R5: bits 2:1 do not alter the span
      wr(6'h00, 32'hFFFF_F007);
      edges(0, "R5");

      // R2: half writes keep the other half
      wr(6'h0C, 32'h0000_0002);
      rd_chk(6'h08, "R2");
      rd_chk(6'h0C, "R2");
      wr(6'h08, 32'h4000_0000);
      rd_chk(6'h0C, "R2");
      rd_chk(6'h00, "R2");
      rd_chk(6'h04, "R2");

      // R7: window 2 overlaps window 0 with 64 KiB
      wr(6'h20, 32'hFFFF_0001);
      wr(6'h28, 32'h2000_0000);
      edges(2, "R7");
      lk_chk(64'h800, "R7");
      sweep(64, "R7");

      // R3: narrow window 1, high half ignored, low write clears upper
      wr(6'h14, 32'h0000_1234);
      rd_chk(6'h14, "R3");
      wr(6'h10, 32'hFFFF_F001);
      wr(6'h18, 32'h0300_0000);
      rd_chk(6'h10, "R3");
      rd_chk(6'h14, "R3");
      lk_chk(64'h0000_0000_0000_2000, "R3");
      lk_chk(64'hFFFF_FFFF_0000_0000, "R3");
      lk_chk(64'hFFFF_FFFF_0000_0FFF, "R3");
      lk_chk(64'hFFFF_FFFF_0000_1000, "R8");
      sweep(64, "R7");

      // R5 / R6: window 2 covers everything, translation wraps
      wr(6'h24, 32'h0000_0000);
      wr(6'h20, 32'h0000_0001);
      wr(6'h2C, 32'hFFFF_FFFF);
      lk_chk(64'hFFFF_FFFF_FFFF_FFF0, "R5");
      lk_chk(64'hFFFF_FFFF_FFFF_FFFF, "R6");
      sweep(64, "R5");

      // R8: disable all windows, everything passes through
      wr(6'h00, 32'hFFFF_F000);
      wr(6'h10, 32'h0);
      wr(6'h20, 32'h0);
      sweep(32, "R8");

      // R9 / R10: status storage and ignored words
      wr(6'h30, 32'hA5A5_5A5A);
      rd_chk(6'h30, "R9");
      wr(6'h38, 32'hDEAD_BEEF);
      rd_chk(6'h38, "R10");
      wr(6'h31, 32'h1111_1111);
      rd_chk(6'h31, "R10");
      rd_chk(6'h30, "R9");
      wr(6'h09, 32'h7777_7777);
      rd_chk(6'h08, "R10");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule